// File: doc/BRIEF.md
# Paged RAM Window Controller

This block lets an 8-bit host CPU reach a large external RAM (4 MB with the default parameters) through a small window of 256 bytes in its I/O address area. Software selects one 256-byte page of the external RAM. The page number is split across three write-only control registers: a low byte, a middle register and a top register. The middle register also carries a RAM-enable flag. While the flag is set, any host read or write in the window is passed to the external RAM. The external RAM address is the selected page number with the low host address byte appended as the offset.

The host side is a plain 6502-style bus: an address, a read/write line, a phase-2 qualifier and separate write and read data paths. A data-bus drive enable goes high only when the external RAM answers a read. The block keeps no data of its own. It has no buffering and no back-pressure, because every host access finishes inside its own bus cycle. Register writes are taken on the rising clock edge at which phase 2 and write are both high. The window translation is combinational on the current host cycle.

Top module: `pwin_ctrl`

## Requirements
- R1: After reset the page number is 0 and RAM is disabled, so a window access does not assert `ram_ce`. Once only the enable is set, window offset N maps to RAM address N.
- R2: A host write to $D1E0 loads page bits [7:0] from the write data.
- R3: A host write to $D1E2 loads page bits [11:8] from write-data bits [3:0]. Bits 7, 6 and 4 of that write have no effect.
- R4: Bit 5 of a $D1E2 write is the RAM-enable flag. It is level-sensitive: a $D1E2 write with bit 5 clear disables the window. For example, writing $02 to $D1E0 and then $01 to $D1E2 selects page $0102 but leaves RAM disabled.
- R5: A host write to $D1E3 loads page bits [13:12] from write-data bits [1:0].
- R6: During an enabled window access, `ram_addr` equals {page[13:0], bus_addr[7:0]}. For example, page $0102 with offset $80 gives $010280.
- R7: While RAM is disabled, window writes do not assert `ram_we` and window reads leave `bus_doe` low.
- R8: `bus_doe` and `ram_oe` are high only when all of these hold: phase 2 is high, the cycle is a read, the address is in $D600 to $D6FF, and RAM is enabled.
- R9: Host addresses outside $D600 to $D6FF never assert `ram_ce`.
- R10: The page and enable state change only on a phase-2 write cycle to $D1E0, $D1E2 or $D1E3. A read of these addresses, a write to $D1E1, or a write with phase 2 low has no effect.
- R11: While `bus_doe` is high, `bus_rdata` carries `ram_rdata`. Otherwise `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_phi2 | input | 1 | Host phase-2 qualifier |
| bus_rw | input | 1 | Host read (1) / write (0) |
| bus_addr | input | 16 | Host address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data returned to the host |
| bus_doe | output | 1 | Host data-bus drive enable |
| ram_addr | output | 22 | External RAM address |
| ram_wdata | output | 8 | External RAM write data |
| ram_rdata | input | 8 | External RAM read data |
| ram_ce | output | 1 | External RAM chip enable |
| ram_we | output | 1 | External RAM write enable |
| ram_oe | output | 1 | External RAM output enable |

## Verification
The bench builds the block with its default parameters: four middle page bits, two top page bits, the enable at bit 5, and the window and register pages at $D6 and $D1. This gives a 14-bit page number. Both the highest page $3FFF and random pages spread over the full 4 MB space are therefore reachable. Random writes toggle the enable bit, which exercises the level-sensitive disable on top of the directed checks of the page-258 example and the ignored-write cases.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_MID  = 2'd2,
    SEL_HI   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwin_decode.sv
module pwin_decode
  import pwin_pkg::*;
#(
  parameter logic [7:0] WIN_PAGE = 8'hD6,
  parameter logic [7:0] REG_PAGE = 8'hD1,
  parameter logic [7:0] LO_OFS   = 8'hE0,
  parameter logic [7:0] MID_OFS  = 8'hE2,
  parameter logic [7:0] HI_OFS   = 8'hE3
) (
  input  logic [15:0] addr,
  output reg_sel_e    sel,
  output logic        win_hit
);
  logic reg_page;

  assign reg_page = (addr[15:8] == REG_PAGE);
  assign win_hit  = (addr[15:8] == WIN_PAGE);

  always_comb begin
    sel = SEL_NONE;
    if (reg_page) begin
      if (addr[7:0] == LO_OFS)       sel = SEL_LO;
      else if (addr[7:0] == MID_OFS) sel = SEL_MID;
      else if (addr[7:0] == HI_OFS)  sel = SEL_HI;
    end
  end
endmodule

// File: rtl/pwin_regs.sv
module pwin_regs
  import pwin_pkg::*;
#(
  parameter int MID_W  = 4,
  parameter int HI_W   = 2,
  parameter int PAGE_W = 8 + MID_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  reg_sel_e          sel,
  input  logic [7:0]        lo_d,
  input  logic [MID_W-1:0]  mid_d,
  input  logic [HI_W-1:0]   hi_d,
  input  logic              en_d,
  output logic [PAGE_W-1:0] page,
  output logic              en
);
  logic [7:0]       lo_q;
  logic [MID_W-1:0] mid_q;
  logic [HI_W-1:0]  hi_q;
  logic             en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      mid_q <= '0;
      hi_q  <= '0;
      en_q  <= 1'b0;
    end else if (wr_stb) begin
      unique case (sel)
        SEL_LO:  lo_q <= lo_d;
        SEL_MID: begin
          mid_q <= mid_d;
          en_q  <= en_d;
        end
        SEL_HI:  hi_q <= hi_d;
        default: ;
      endcase
    end
  end

  assign page = {hi_q, mid_q, lo_q};
  assign en   = en_q;
endmodule

// File: rtl/pwin_xlate.sv
module pwin_xlate #(
  parameter int PAGE_W = 14,
  parameter int RAM_AW = PAGE_W + 8
) (
  input  logic              phi2,
  input  logic              rw,
  input  logic              win_hit,
  input  logic              en,
  input  logic [PAGE_W-1:0] page,
  input  logic [7:0]        addr_lo,
  input  logic [7:0]        wdata,
  input  logic [7:0]        ram_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              ram_ce,
  output logic              ram_we,
  output logic              ram_oe,
  output logic [7:0]        bus_rdata,
  output logic              bus_doe
);
  logic live;

  assign live      = phi2 & win_hit & en;
  assign ram_addr  = {page, addr_lo};
  assign ram_wdata = wdata;
  assign ram_ce    = live;
  assign ram_we    = live & ~rw;
  assign ram_oe    = live & rw;
  assign bus_doe   = ram_oe;
  assign bus_rdata = ram_oe ? ram_rdata : 8'h00;
endmodule

// File: rtl/pwin_ctrl.sv
module pwin_ctrl
  import pwin_pkg::*;
#(
  parameter logic [7:0] WIN_PAGE = 8'hD6,
  parameter logic [7:0] REG_PAGE = 8'hD1,
  parameter logic [7:0] LO_OFS   = 8'hE0,
  parameter logic [7:0] MID_OFS  = 8'hE2,
  parameter logic [7:0] HI_OFS   = 8'hE3,
  parameter int         MID_W    = 4,
  parameter int         HI_W     = 2,
  parameter int         EN_BIT   = 5,
  localparam int        PAGE_W   = 8 + MID_W + HI_W,
  localparam int        RAM_AW   = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_phi2,
  input  logic              bus_rw,
  input  logic [15:0]       bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_doe,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              ram_ce,
  output logic              ram_we,
  output logic              ram_oe
);
  reg_sel_e          sel;
  logic              win_hit;
  logic              wr_stb;
  logic [PAGE_W-1:0] page_q;
  logic              en_q;

  assign wr_stb = bus_phi2 & ~bus_rw;

  pwin_decode #(
    .WIN_PAGE(WIN_PAGE), .REG_PAGE(REG_PAGE),
    .LO_OFS(LO_OFS), .MID_OFS(MID_OFS), .HI_OFS(HI_OFS)
  ) u_dec (
    .addr(bus_addr), .sel(sel), .win_hit(win_hit)
  );

  pwin_regs #(.MID_W(MID_W), .HI_W(HI_W), .PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .sel(sel),
    .lo_d(bus_wdata), .mid_d(bus_wdata[MID_W-1:0]),
    .hi_d(bus_wdata[HI_W-1:0]), .en_d(bus_wdata[EN_BIT]),
    .page(page_q), .en(en_q)
  );

  pwin_xlate #(.PAGE_W(PAGE_W), .RAM_AW(RAM_AW)) u_xl (
    .phi2(bus_phi2), .rw(bus_rw), .win_hit(win_hit), .en(en_q),
    .page(page_q), .addr_lo(bus_addr[7:0]), .wdata(bus_wdata),
    .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_ce(ram_ce), .ram_we(ram_we), .ram_oe(ram_oe),
    .bus_rdata(bus_rdata), .bus_doe(bus_doe)
  );
endmodule

// File: rtl/pwin_checker.sv
module pwin_checker #(
  parameter logic [7:0] WIN_PAGE = 8'hD6,
  parameter logic [7:0] REG_PAGE = 8'hD1,
  parameter logic [7:0] LO_OFS   = 8'hE0,
  parameter logic [7:0] MID_OFS  = 8'hE2,
  parameter logic [7:0] HI_OFS   = 8'hE3,
  parameter int         MID_W    = 4,
  parameter int         HI_W     = 2,
  parameter int         EN_BIT   = 5,
  parameter int         PAGE_W   = 8 + MID_W + HI_W,
  parameter int         RAM_AW   = PAGE_W + 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_phi2,
  input logic              bus_rw,
  input logic [15:0]       bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_doe,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              ram_ce,
  input logic              ram_we,
  input logic [PAGE_W-1:0] page,
  input logic              en
);
  logic wr_cyc;
  assign wr_cyc = bus_phi2 & ~bus_rw;

  p_lo_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && bus_addr == {REG_PAGE, LO_OFS}) |=> (page[7:0] == $past(bus_wdata)));

  p_mid_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && bus_addr == {REG_PAGE, MID_OFS})
      |=> (page[8+MID_W-1:8] == $past(bus_wdata[MID_W-1:0])));

  p_en_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && bus_addr == {REG_PAGE, MID_OFS}) |=> (en == $past(bus_wdata[EN_BIT])));

  p_hi_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && bus_addr == {REG_PAGE, HI_OFS})
      |=> (page[PAGE_W-1:8+MID_W] == $past(bus_wdata[HI_W-1:0])));

  p_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce |-> (ram_addr[7:0] == bus_addr[7:0] && ram_addr[RAM_AW-1:8] == page));

  p_dis_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!ram_we && !bus_doe));

  p_doe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (bus_phi2 && bus_rw && en && bus_addr[15:8] == WIN_PAGE));

  p_win_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:8] != WIN_PAGE) |-> !ram_ce);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cyc |=> ($stable(page) && $stable(en)));
endmodule

bind pwin_ctrl pwin_checker #(
  .WIN_PAGE(WIN_PAGE), .REG_PAGE(REG_PAGE), .LO_OFS(LO_OFS),
  .MID_OFS(MID_OFS), .HI_OFS(HI_OFS), .MID_W(MID_W), .HI_W(HI_W),
  .EN_BIT(EN_BIT), .PAGE_W(PAGE_W), .RAM_AW(RAM_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_phi2(bus_phi2), .bus_rw(bus_rw),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_doe(bus_doe),
  .ram_addr(ram_addr), .ram_ce(ram_ce), .ram_we(ram_we),
  .page(page_q), .en(en_q)
);

// File: tb/tb_pwin_ctrl.sv
module tb_pwin_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_phi2 = 1'b0;
  logic        bus_rw = 1'b1;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        bus_doe;
  logic [21:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata;
  logic        ram_ce, ram_we, ram_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [13:0] m_page = '0;
  logic        m_en = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] ram_model(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
  endfunction

  assign ram_rdata = ram_model(ram_addr);

  pwin_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_phi2(bus_phi2), .bus_rw(bus_rw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_doe(bus_doe), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .ram_ce(ram_ce), .ram_we(ram_we), .ram_oe(ram_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // One host bus cycle; outputs checked mid-cycle, model updated at the edge.
  task automatic access(input logic [15:0] a, input logic rd, input logic [7:0] d);
    logic hit;
    @(negedge clk);
    bus_phi2 = 1'b1; bus_rw = rd; bus_addr = a; bus_wdata = d;
    #1;
    hit = (a[15:8] == 8'hD6) && m_en;
    chk("R9/R1 ram_ce", ram_ce, hit);
    chk("R8 bus_doe", bus_doe, hit & rd);
    chk("R8 ram_oe", ram_oe, hit & rd);
    chk("R7 ram_we", ram_we, hit & ~rd);
    if (hit) chk("R6 ram_addr", ram_addr, {m_page, a[7:0]});
    if (hit & ~rd) chk("R6 ram_wdata", ram_wdata, d);
    chk("R11 bus_rdata", bus_rdata, (hit & rd) ? ram_model({m_page, a[7:0]}) : 8'h00);
    @(posedge clk);
    if (!rd) begin
      if (a == 16'hD1E0) m_page[7:0] = d;
      if (a == 16'hD1E2) begin m_page[11:8] = d[3:0]; m_en = d[5]; end
      if (a == 16'hD1E3) m_page[13:12] = d[1:0];
    end
    #1;
    bus_phi2 = 1'b0; bus_rw = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h00C0FFEE);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state -- window disabled
    access(16'hD605, 1'b1, 8'h00);
    access(16'hD605, 1'b0, 8'h33);
    // R1: enable only, page still zero -> offset maps to address N
    access(16'hD1E2, 1'b0, 8'h20);
    @(negedge clk); bus_phi2 = 1'b1; bus_rw = 1'b1; bus_addr = 16'hD605; #1;
    chk("R1 page zero after reset", ram_addr, 22'h000005);
    @(posedge clk); #1 bus_phi2 = 1'b0;

    // R2/R3/R4: page 258 example; $01 alone leaves RAM disabled
    access(16'hD1E0, 1'b0, 8'h02);
    access(16'hD1E2, 1'b0, 8'h01);
    access(16'hD680, 1'b1, 8'h00);
    chk("R4 disabled by bit5 clear", {31'd0, m_en}, 32'd0);
    access(16'hD1E2, 1'b0, 8'h21);
    @(negedge clk); bus_phi2 = 1'b1; bus_rw = 1'b1; bus_addr = 16'hD680; #1;
    chk("R6 page 258 address", ram_addr, 22'h010280);
    chk("R4 enabled by bit5 set", ram_ce, 1'b1);
    @(posedge clk); #1 bus_phi2 = 1'b0;
    access(16'hD680, 1'b0, 8'hBE);

    // R5/R3: highest page, ignored high bits of mid register
    access(16'hD1E3, 1'b0, 8'hFF);
    access(16'hD1E0, 1'b0, 8'hFF);
    access(16'hD1E2, 1'b0, 8'hFF);
    @(negedge clk); bus_phi2 = 1'b1; bus_rw = 1'b1; bus_addr = 16'hD6FE; #1;
    chk("R5 top page address", ram_addr, 22'h3FFFFE);
    @(posedge clk); #1 bus_phi2 = 1'b0;

    // R10: write with phase 2 low has no effect
    @(negedge clk); bus_phi2 = 1'b0; bus_rw = 1'b0; bus_addr = 16'hD1E0; bus_wdata = 8'h00;
    @(posedge clk); #1 bus_rw = 1'b1;
    access(16'hD6FE, 1'b1, 8'h00);
    // R10: register reads and the unused offset leave state alone
    access(16'hD1E0, 1'b1, 8'h00);
    access(16'hD1E1, 1'b0, 8'h00);
    access(16'hD6FE, 1'b1, 8'h00);
    // R9: neighbouring pages never reach RAM
    access(16'hD700, 1'b1, 8'h00);
    access(16'hD5FF, 1'b0, 8'h12);

    // Random mix over registers, window and elsewhere
    for (int i = 0; i < 600; i++) begin
      int unsigned k;
      logic [15:0] a;
      k = $urandom_range(0, 9);
      case (k)
        0: a = 16'hD1E0;
        1: a = 16'hD1E2;
        2: a = 16'hD1E3;
        3: a = {8'hD1, 8'($urandom)};
        4: a = 16'($urandom);
        default: a = {8'hD6, 8'($urandom)};
      endcase
      access(a, 1'($urandom), 8'($urandom));
    end

    summary();
  end
endmodule